// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer reached through a small word-addressed register bus. A 16-bit down-counter is advanced by a tick derived from the system clock in two stages. First comes an 8-bit programmable prescaler, then a fixed power-of-two divider chosen from four settings. If software does not refresh the counter before it runs out, the block raises an interrupt, a system reset pulse, or both, depending on two independent enable bits.

Software programs a reload value and loads the live counter. It then sets the run bit in the control word. While the timer runs, software refreshes it periodically by writing the count register. On expiry the counter reloads itself from the reload register and keeps counting. A pending interrupt stays raised until software clears it through a write-one-to-clear status word.

Top module: `wdt_top`

## Requirements
- R1: After reset the control word reads 0xFF1B (run on, reset output on, interrupt off, divider select 3, prescaler field 0xFF), the reload and count words both read 0x8000, and irq_o and sys_rst_o are low.
- R2: The control word at byte address 0x0 holds run in bit 0, reset enable in bit 1, interrupt enable in bit 2, the divider select in bits 4:3 and the prescaler field in bits 15:8. The reload word sits at 0x4, the live count at 0x8 and the interrupt status at 0xC. Read data appears on bus_rdata one clock after the read strobe.
- R3: While running, the tick period is (P+1)·D system clocks. P is the prescaler field, and D is 16, 32, 64 or 128 for divider select 0, 1, 2 or 3.
- R4: With the counter loaded to N, expiry occurs on the (N+1)th tick. The first expiry output is visible (N+1)·T+1 clocks after the enabling write, where T is the tick period. The counter then reloads from the reload word, so later expiries follow every (N+1)·T clocks.
- R5: A write to the count word loads the live counter with the written value and restarts the prescaler and divider. The next expiry is therefore (N+1)·T+1 clocks after that write.
- R6: On expiry with interrupt enable set, irq_o goes high and stays high until a write with bit 0 set reaches address 0xC. Writing 0 there leaves it high.
- R7: On expiry with reset enable set, sys_rst_o is high for exactly 128 consecutive clocks.
- R8: Clearing the run bit freezes the live counter and prevents any expiry. The reload word and the other control fields keep their values.
- R9: The two outputs are independent: with only interrupt enable set, sys_rst_o stays low, and with only reset enable set, irq_o stays low.
- R10: The start sequence of reload write, count write and then a control write with run set produces no output before the full programmed period has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe for one clock |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address, word aligned |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt level, held until cleared |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
Expiry timing is measured to the exact clock for several prescaler and divider combinations. Each combination puts a different factor into the period, so an error in either stage shows up as a wrong count. Interrupt-only and reset-only configurations tell apart the two enables and the pulse length. A mid-run refresh separates a counter load that restarts the tick chain from one that does not. A run that is stopped and then left idle shows whether the counter truly freezes and whether the other fields survive.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef struct packed {
    logic [7:0] pre;
    logic [2:0] spare;
    logic [1:0] div_sel;
    logic       irq_en;
    logic       rst_en;
    logic       run;
  } wdt_ctrl_t;

  localparam logic [1:0] SLOT_CTRL   = 2'd0;
  localparam logic [1:0] SLOT_RELOAD = 2'd1;
  localparam logic [1:0] SLOT_COUNT  = 2'd2;
  localparam logic [1:0] SLOT_STATUS = 2'd3;

  localparam wdt_ctrl_t CTRL_AT_RESET = '{pre: 8'hFF, spare: 3'd0, div_sel: 2'd3,
                                          irq_en: 1'b0, rst_en: 1'b1, run: 1'b1};

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter logic [CNT_W-1:0] RELOAD_INIT = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [3:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              irq_i,
  output wdt_ctrl_t         ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              cnt_wr_o,
  output logic [CNT_W-1:0]  cnt_val_o,
  output logic              irq_clr_o
);

  logic       aligned;
  logic [1:0] slot;
  logic       wr_hit;
  logic       rd_hit;

  assign aligned = (addr[1:0] == 2'b00);
  assign slot    = addr[3:2];
  assign wr_hit  = sel && we && aligned;
  assign rd_hit  = sel && !we && aligned;

  assign cnt_wr_o  = wr_hit && (slot == SLOT_COUNT);
  assign cnt_val_o = CNT_W'(wdata);
  assign irq_clr_o = wr_hit && (slot == SLOT_STATUS) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o   <= CTRL_AT_RESET;
      reload_o <= RELOAD_INIT;
    end else if (wr_hit) begin
      if (slot == SLOT_CTRL)   ctrl_o   <= wdt_ctrl_t'(wdata[15:0]);
      if (slot == SLOT_RELOAD) reload_o <= CNT_W'(wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_hit) begin
      case (slot)
        SLOT_CTRL:   rdata <= DATA_W'(ctrl_o);
        SLOT_RELOAD: rdata <= DATA_W'(reload_o);
        SLOT_COUNT:  rdata <= DATA_W'(cnt_i);
        default:     rdata <= DATA_W'(irq_i);
      endcase
    end
  end

endmodule

// File: rtl/wdt_tick.sv
module wdt_tick #(
  parameter int PRE_W        = 8,
  parameter int MIN_DIV_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [PRE_W-1:0] pre,
  input  logic [1:0]       div_sel,
  output logic             tick
);

  localparam int DIV_W   = MIN_DIV_LOG2 + 4;
  localparam int MIN_DIV = 1 << MIN_DIV_LOG2;

  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_last;
  logic             pre_hit;

  assign pre_hit = (pre_cnt == pre);

  always_comb begin
    div_last = (DIV_W'(MIN_DIV) << div_sel) - DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (pre_hit) begin
        pre_cnt <= '0;
        if (div_cnt == div_last) begin
          div_cnt <= '0;
          tick    <= 1'b1;
        end else begin
          div_cnt <= div_cnt + DIV_W'(1);
        end
      end else begin
        pre_cnt <= pre_cnt + PRE_W'(1);
      end
    end
  end

  // R3: a tick never follows a cycle in which the chain was held clear
  a_r3_tick_after_clear: assert property (@(posedge clk) disable iff (rst)
    tick |-> !$past(clr));

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] CNT_INIT = 16'h8000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);

  assign expire = run && tick && !ld && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CNT_INIT;
    end else if (ld) begin
      cnt <= ld_val;
    end else if (expire) begin
      cnt <= reload;
    end else if (run && tick) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R5: a count write lands in the live counter
  a_r5_refresh_load: assert property (@(posedge clk) disable iff (rst)
    ld |=> cnt == $past(ld_val));

  // R4: expiry reloads from the reload word
  a_r4_auto_reload: assert property (@(posedge clk) disable iff (rst)
    expire |=> cnt == $past(reload));

  // R8: a stopped timer holds its count
  a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
    (!run && !ld) |=> $stable(cnt));

endmodule

// File: rtl/wdt_out.sv
module wdt_out #(
  parameter int RST_LEN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic irq_en,
  input  logic rst_en,
  input  logic irq_clr,
  output logic irq_o,
  output logic sys_rst_o
);

  localparam int RW = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;

  logic [RW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
    end else if (expire && irq_en) begin
      irq_o <= 1'b1;
    end else if (irq_clr) begin
      irq_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_rst_o <= 1'b0;
      left      <= '0;
    end else if (expire && rst_en) begin
      sys_rst_o <= 1'b1;
      left      <= RW'(RST_LEN - 1);
    end else if (sys_rst_o) begin
      if (left == '0) sys_rst_o <= 1'b0;
      else            left      <= left - RW'(1);
    end
  end

  // R6: an enabled expiry raises the interrupt
  a_r6_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (expire && irq_en) |=> irq_o);

  // R6: the interrupt only drops on a clear strobe
  a_r6_irq_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_clr) |=> irq_o);

  // R7: a reset pulse starts only from an enabled expiry
  a_r7_rst_origin: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> $past(expire && rst_en));

  // R9: with reset output off, no new reset pulse begins
  a_r9_rst_gated: assert property (@(posedge clk) disable iff (rst)
    (!sys_rst_o && !(expire && rst_en)) |=> !sys_rst_o);

endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int CNT_W        = 16,
  parameter int PRE_W        = 8,
  parameter int MIN_DIV_LOG2 = 4,
  parameter int RST_LEN      = 128,
  parameter logic [CNT_W-1:0] RELOAD_INIT = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              sys_rst_o
);

  wdt_ctrl_t        ctrl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_wr;
  logic             irq_clr;
  logic             tick;
  logic             expire;

  wdt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .cnt_i(cnt), .irq_i(irq_o),
    .ctrl_o(ctrl), .reload_o(reload), .cnt_wr_o(cnt_wr),
    .cnt_val_o(cnt_val), .irq_clr_o(irq_clr)
  );

  wdt_tick #(.PRE_W(PRE_W), .MIN_DIV_LOG2(MIN_DIV_LOG2)) u_tick (
    .clk(clk), .rst(rst), .clr(!ctrl.run || cnt_wr),
    .pre(ctrl.pre), .div_sel(ctrl.div_sel), .tick(tick)
  );

  wdt_count #(.CNT_W(CNT_W), .CNT_INIT(RELOAD_INIT)) u_count (
    .clk(clk), .rst(rst), .run(ctrl.run), .tick(tick), .ld(cnt_wr),
    .ld_val(cnt_val), .reload(reload), .cnt(cnt), .expire(expire)
  );

  wdt_out #(.RST_LEN(RST_LEN)) u_out (
    .clk(clk), .rst(rst), .expire(expire), .irq_en(ctrl.irq_en),
    .rst_en(ctrl.rst_en), .irq_clr(irq_clr), .irq_o(irq_o),
    .sys_rst_o(sys_rst_o)
  );

  // R8: no expiry while stopped
  a_r8_no_expiry_stopped: assert property (@(posedge clk) disable iff (rst)
    !ctrl.run |-> !expire);

endmodule

// File: tb/wdt_top_bench.sv
module wdt_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_o;
  logic        sys_rst_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  wdt_top u_wdt_top (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [15:0] cw(input int pre, input int dv, input bit ie,
                                     input bit re, input bit en);
    return 16'((pre << 8) | (dv << 3) | (int'(ie) << 2) | (int'(re) << 1) | int'(en));
  endfunction

  // posedges until the chosen output is high; 0 = irq, 1 = reset
  task automatic wait_high(input bit which, output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if ((which ? sys_rst_o : irq_o) == 1'b1) break;
    end
  endtask

  task automatic setup(input int pre, input int dv, input bit ie, input bit re, input int n);
    wr(4'h0, 16'h0000);
    wr(4'hC, 16'h0001);
    wr(4'h4, 16'(n));
    wr(4'h8, 16'(n));
    wr(4'h0, cw(pre, dv, ie, re, 1'b1));
    check(irq_o == 1'b0 && sys_rst_o == 1'b0, "R10 quiet after start", irq_o, 0);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(4'h0, d); check(d == 16'hFF1B, "R1 ctrl reset", d, 16'hFF1B);
    rd(4'h4, d); check(d == 16'h8000, "R1 reload reset", d, 16'h8000);
    rd(4'h8, d); check(d == 16'h8000, "R1 count reset", d, 16'h8000);
    check(irq_o == 1'b0, "R1 irq reset", irq_o, 0);
    check(sys_rst_o == 1'b0, "R1 sys_rst reset", sys_rst_o, 0);
  endtask

  task automatic t_irq_only;
    int n;
    setup(0, 0, 1'b1, 1'b0, 3);
    wait_high(1'b0, n);
    check(n == 65, "R3 R4 first expiry", n, 65);
    check(sys_rst_o == 1'b0, "R9 no reset with irq only", sys_rst_o, 0);
    wr(4'hC, 16'h0001);
    check(irq_o == 1'b0, "R6 cleared", irq_o, 0);
    wait_high(1'b0, n);
    check(n == 63, "R4 auto reload period", n, 63);
    wr(4'hC, 16'h0000);
    check(irq_o == 1'b1, "R6 zero write keeps irq", irq_o, 1);
    wr(4'h0, 16'h0000);
    wr(4'hC, 16'h0001);
  endtask

  task automatic t_rst_only(input int pre, input int dv, input int n, input int exp);
    int m;
    int w;
    setup(pre, dv, 1'b0, 1'b1, n);
    wait_high(1'b1, m);
    check(m == exp, "R3 R4 reset expiry time", m, exp);
    w = 1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!sys_rst_o) break;
      w++;
    end
    check(w == 128, "R7 pulse width", w, 128);
    check(irq_o == 1'b0, "R9 no irq with reset only", irq_o, 0);
    wr(4'h0, 16'h0000);
  endtask

  task automatic t_refresh;
    int n;
    setup(0, 0, 1'b1, 1'b0, 9);
    repeat (100) @(negedge clk);
    check(irq_o == 1'b0, "R5 no expiry before refresh", irq_o, 0);
    wr(4'h8, 16'd9);
    wait_high(1'b0, n);
    check(n == 161, "R5 refresh restarts period", n, 161);
    wr(4'h0, 16'h0000);
    wr(4'hC, 16'h0001);
  endtask

  task automatic t_stop;
    logic [15:0] c1;
    logic [15:0] c2;
    logic [15:0] d;
    bit seen;
    setup(0, 0, 1'b1, 1'b1, 20);
    repeat (50) @(negedge clk);
    wr(4'h0, 16'h0004);
    rd(4'h8, c1);
    seen = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (irq_o || sys_rst_o) seen = 1'b1;
    end
    rd(4'h8, c2);
    check(c1 == c2, "R8 count frozen", c2, c1);
    check(c1 < 16'd20 && c1 > 16'd0, "R8 count had advanced", c1, 17);
    check(!seen, "R8 no output when stopped", seen, 0);
    rd(4'h4, d); check(d == 16'd20, "R8 reload kept", d, 20);
    rd(4'h0, d); check(d == 16'h0004, "R2 R8 ctrl fields kept", d, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    wr(4'h0, 16'h0000);
    t_irq_only();
    t_rst_only(2, 1, 1, 193);
    t_rst_only(0, 3, 1, 257);
    t_rst_only(1, 2, 2, 385);
    t_refresh();
    t_stop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule